// File: doc/BRIEF.md
# Echo Canceller Group Mode Router

This block sits between two timeslot-multiplexed sample streams and a bank of echo canceller engines. The engines are arranged as 16 groups of two, called engine A and engine B. Each engine has a primary control register and an auxiliary control register, reached over a small synchronous bus. Timeslot `2g` on each port belongs to engine A of group `g`, and timeslot `2g+1` belongs to engine B.

The block decodes each group into one of three modes:

- **Parallel:** two independent 64 ms channels.
- **Back-to-back:** one channel is cancelled in both directions. Engine A works on the port-1 to port-2 direction. Engine B works on the reverse direction, with its inputs swapped.
- **Extended:** engine A feeds engine B as one 128 ms canceller.

Two lane interfaces carry the work to the engines. Each lane carries the samples, a long-tail flag and a DC-stage bypass flag, and lane B also carries a cascade flag. The engines return one result per lane one cycle after the request. The block then builds the outgoing timeslot on both ports. In the folded modes (back-to-back and extended), the partner timeslot is forced to zero.

A mode change is staged in the registers. It is applied only on a frame-sync pulse, so one frame never mixes two routings.

Top module: `ecg_group_router`

## Requirements
- R1: After reset, all control registers read 0, every group is in parallel mode, `cfg_err` is 0, and all lane and output valid signals are low.
- R2: A write stores `cfg_wdata` in the register selected by `cfg_addr` (the engine number; odd numbers are B engines) and `cfg_page` (0 = primary, 1 = auxiliary). `cfg_rdata` returns the stored value in the same cycle. Bit 0 of a B engine's primary register always reads 0.
- R3: In parallel mode, an even slot drives lane A only and an odd slot drives lane B only. Both lanes use rin = `p1_in` and sin = `p2_in`. `p2_out` is that lane's engine result and `p1_out` is `p1_in`.
- R4: Back-to-back mode is selected only when primary bit 1 is set in both the A and the B register of the group. With only one of them set, the group stays in parallel mode.
- R5: In back-to-back mode, an even slot drives both lanes. Lane A gets rin = `p1_in` and sin = `p2_in`; lane B gets rin = `p2_in` and sin = `p1_in`. `p2_out` is the lane A result and `p1_out` is the lane B result.
- R6: Primary bit 0 of the A register selects extended mode. An even slot then drives both lanes with rin = `p1_in` and sin = `p2_in`. Both long-tail flags and `lane_b_casc` are set. `p2_out` is the lane B result and `p1_out` is `p1_in`.
- R7: In back-to-back and extended modes, an odd slot drives no lane. Its output slot is still marked valid, with `p1_out` = `p2_out` = 0.
- R8: When extended mode and both pair bits are set together, extended mode wins and `cfg_err[g]` is 1. Otherwise `cfg_err[g]` is 0.
- R9: A register change does not alter routing until `frame_sync` is high. A slot presented in the same cycle as `frame_sync` already uses the new mode, and `act_mode` changes only on that edge.
- R10: Auxiliary bit 0 of an engine's register appears as that engine's lane bypass flag, taken when its slot is issued.
- R11: Lane requests appear 1 cycle after the slot. The output slot (`out_vld`, `out_idx`, `p1_out`, `p2_out`) appears exactly 3 cycles after the slot, and `out_vld` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_page | input | 1 | 0 = primary register, 1 = auxiliary register |
| cfg_addr | input | 5 | Engine number (2g = A, 2g+1 = B) |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for the addressed register |
| cfg_err | output | 16 | Per-group conflicting-configuration flag |
| frame_sync | input | 1 | Frame boundary; applies the staged modes |
| ts_valid | input | 1 | Incoming slot strobe |
| ts_idx | input | 5 | Incoming slot number |
| p1_in | input | 16 | Port-1 (receive) sample |
| p2_in | input | 16 | Port-2 (send) sample |
| lane_a_vld | output | 1 | Request to engine A of `lane_a_grp` |
| lane_a_grp | output | 4 | Group served on lane A |
| lane_a_rin | output | 16 | Lane A reference sample |
| lane_a_sin | output | 16 | Lane A echo-bearing sample |
| lane_a_long | output | 1 | Lane A runs as the head of a 128 ms tail |
| lane_a_byp | output | 1 | Lane A DC stage bypass |
| lane_b_vld | output | 1 | Request to engine B of `lane_b_grp` |
| lane_b_grp | output | 4 | Group served on lane B |
| lane_b_rin | output | 16 | Lane B reference sample |
| lane_b_sin | output | 16 | Lane B echo-bearing sample |
| lane_b_long | output | 1 | Lane B runs as part of a 128 ms tail |
| lane_b_casc | output | 1 | Lane B continues engine A's tail |
| lane_b_byp | output | 1 | Lane B DC stage bypass |
| lane_a_res | input | 16 | Engine A result, one cycle after the request |
| lane_b_res | input | 16 | Engine B result, one cycle after the request |
| out_vld | output | 1 | Outgoing slot strobe |
| out_idx | output | 5 | Outgoing slot number |
| p1_out | output | 16 | Port-1 outgoing sample |
| p2_out | output | 16 | Port-2 outgoing sample |

## Verification
A wrongly decoded or wrongly latched group mode shows up one cycle after the next slot of that group. It appears as a missing or extra lane request, swapped lane samples, or a wrong long-tail or cascade flag. Three cycles after that slot, the same fault shows as a wrong choice of engine result or a non-zero partner slot. A mode register that updates outside a frame boundary is exposed by giving a slot a new configuration without `frame_sync` and checking that the old routing is still used. Register storage faults are visible in the same cycle on `cfg_rdata`.

// File: rtl/ecg_route_pkg.sv
// Shared types and constants for the echo canceller group router.
// Assumes: mode encodings are internal; only register bit positions are visible
// to software.
package ecg_route_pkg;

    typedef enum logic [1:0] {
        MODE_PAR = 2'd0,
        MODE_B2B = 2'd1,
        MODE_EXT = 2'd2
    } grp_mode_e;

    // primary register: extended-tail select (A engine only)
    localparam int CTL_EXT_BIT  = 0;
    // primary register: bidirectional pair request (both engines)
    localparam int CTL_PAIR_BIT = 1;
    // auxiliary register: DC stage bypass
    localparam int AUX_BYP_BIT  = 0;

    // Extended wins over the pair request; pair needs both halves.
    function automatic grp_mode_e decode_mode(input logic ext, input logic pair_a,
                                              input logic pair_b);
        if (ext)
            return MODE_EXT;
        if (pair_a && pair_b)
            return MODE_B2B;
        return MODE_PAR;
    endfunction

endpackage

// File: rtl/ecg_cfg_regs.sv
// Register file: one primary and one auxiliary register per engine.
// Assumes: engine number LSB selects B; writes land on the clock edge;
// reads are combinational from the stored values.
module ecg_cfg_regs
    import ecg_route_pkg::*;
#(
    parameter int NG = 16,
    parameter int DW = 8,
    parameter int AW = $clog2(2 * NG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_page,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    output logic [NG-1:0] ext_req,
    output logic [NG-1:0] pair_a,
    output logic [NG-1:0] pair_b,
    output logic [2*NG-1:0] byp
);

    localparam int NE = 2 * NG;
    localparam logic [DW-1:0] B_MASK = ~(DW'(1) << CTL_EXT_BIT);

    logic [DW-1:0] ctl_q [NE];
    logic [DW-1:0] aux_q [NE];

    // Store writes; the extended bit of a B engine is never kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NE; e++) begin
                ctl_q[e] <= '0;
                aux_q[e] <= '0;
            end
        end else if (cfg_wr) begin
            if (!cfg_page)
                ctl_q[cfg_addr] <= cfg_addr[0] ? (cfg_wdata & B_MASK) : cfg_wdata;
            else
                aux_q[cfg_addr] <= cfg_wdata;
        end
    end

    // Read mux for the addressed register.
    always_comb begin
        cfg_rdata = cfg_page ? aux_q[cfg_addr] : ctl_q[cfg_addr];
    end

    // Fan out the decode-relevant bits per group and per engine.
    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign ext_req[g]   = ctl_q[2*g][CTL_EXT_BIT];
        assign pair_a[g]    = ctl_q[2*g][CTL_PAIR_BIT];
        assign pair_b[g]    = ctl_q[2*g+1][CTL_PAIR_BIT];
        assign byp[2*g]     = aux_q[2*g][AUX_BYP_BIT];
        assign byp[2*g+1]   = aux_q[2*g+1][AUX_BYP_BIT];
    end

endmodule

// File: rtl/ecg_mode_ctrl.sv
// Per-group mode decode with frame-boundary application.
// Assumes: frame_sync is a single-cycle pulse; a slot presented with the pulse
// belongs to the new frame and sees the new mode.
module ecg_mode_ctrl
    import ecg_route_pkg::*;
#(
    parameter int NG = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_sync,
    input  logic [NG-1:0]      ext_req,
    input  logic [NG-1:0]      pair_a,
    input  logic [NG-1:0]      pair_b,
    output logic [NG-1:0]      cfg_err,
    output logic [NG-1:0][1:0] act_mode,
    output logic [NG-1:0][1:0] eff_mode
);

    logic [NG-1:0][1:0] pend_mode;

    for (genvar g = 0; g < NG; g++) begin : g_dec
        // Staged mode and conflict flag from the current register contents.
        assign pend_mode[g] = decode_mode(ext_req[g], pair_a[g], pair_b[g]);
        assign cfg_err[g]   = ext_req[g] & pair_a[g] & pair_b[g];

        // Active mode only moves on a frame boundary.
        always_ff @(posedge clk) begin
            if (!rst_n)
                act_mode[g] <= MODE_PAR;
            else if (frame_sync)
                act_mode[g] <= pend_mode[g];
        end

        // Mode seen by a slot arriving this cycle.
        assign eff_mode[g] = frame_sync ? pend_mode[g] : act_mode[g];
    end

endmodule

// File: rtl/ecg_lane_issue.sv
// Stage 1: turns an incoming slot into engine lane requests.
// Assumes: slot 2g maps to engine A of group g, slot 2g+1 to engine B.
module ecg_lane_issue
    import ecg_route_pkg::*;
#(
    parameter int NG = 16,
    parameter int SW = 16,
    parameter int AW = $clog2(2 * NG),
    parameter int GW = $clog2(NG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ts_valid,
    input  logic [AW-1:0]      ts_idx,
    input  logic [SW-1:0]      p1_in,
    input  logic [SW-1:0]      p2_in,
    input  logic [NG-1:0][1:0] eff_mode,
    input  logic [2*NG-1:0]    byp,
    output logic               lane_a_vld,
    output logic [GW-1:0]      lane_a_grp,
    output logic [SW-1:0]      lane_a_rin,
    output logic [SW-1:0]      lane_a_sin,
    output logic               lane_a_long,
    output logic               lane_a_byp,
    output logic               lane_b_vld,
    output logic [GW-1:0]      lane_b_grp,
    output logic [SW-1:0]      lane_b_rin,
    output logic [SW-1:0]      lane_b_sin,
    output logic               lane_b_long,
    output logic               lane_b_casc,
    output logic               lane_b_byp,
    output logic               s1_vld,
    output logic [AW-1:0]      s1_idx,
    output logic [1:0]         s1_mode,
    output logic [SW-1:0]      s1_p1
);

    logic [GW-1:0] grp;
    logic          odd;
    logic [1:0]    mode;
    logic          use_a;
    logic          use_b;
    logic          swap_b;
    logic          is_ext;

    // Decide which lanes a slot occupies and how lane B is fed.
    always_comb begin
        grp    = ts_idx[AW-1:1];
        odd    = ts_idx[0];
        mode   = eff_mode[grp];
        is_ext = (mode == MODE_EXT);
        swap_b = (mode == MODE_B2B);
        use_a  = ts_valid & ~odd;
        use_b  = ts_valid & (odd ? (mode == MODE_PAR) : (mode != MODE_PAR));
    end

    // Register the lane A request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_a_vld  <= 1'b0;
            lane_a_grp  <= '0;
            lane_a_rin  <= '0;
            lane_a_sin  <= '0;
            lane_a_long <= 1'b0;
            lane_a_byp  <= 1'b0;
        end else begin
            lane_a_vld  <= use_a;
            lane_a_grp  <= use_a ? grp : '0;
            lane_a_rin  <= use_a ? p1_in : '0;
            lane_a_sin  <= use_a ? p2_in : '0;
            lane_a_long <= use_a & is_ext;
            lane_a_byp  <= use_a & byp[{grp, 1'b0}];
        end
    end

    // Register the lane B request; reverse direction in back-to-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_b_vld  <= 1'b0;
            lane_b_grp  <= '0;
            lane_b_rin  <= '0;
            lane_b_sin  <= '0;
            lane_b_long <= 1'b0;
            lane_b_casc <= 1'b0;
            lane_b_byp  <= 1'b0;
        end else begin
            lane_b_vld  <= use_b;
            lane_b_grp  <= use_b ? grp : '0;
            lane_b_rin  <= !use_b ? '0 : (swap_b ? p2_in : p1_in);
            lane_b_sin  <= !use_b ? '0 : (swap_b ? p1_in : p2_in);
            lane_b_long <= use_b & is_ext;
            lane_b_casc <= use_b & is_ext;
            lane_b_byp  <= use_b & byp[{grp, 1'b1}];
        end
    end

    // Carry slot context toward output assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_idx  <= '0;
            s1_mode <= MODE_PAR;
            s1_p1   <= '0;
        end else begin
            s1_vld  <= ts_valid;
            s1_idx  <= ts_idx;
            s1_mode <= mode;
            s1_p1   <= p1_in;
        end
    end

endmodule

// File: rtl/ecg_out_build.sv
// Stages 2 and 3: waits for engine results and assembles the outgoing slot.
// Assumes: engines return lane results exactly one cycle after the request.
module ecg_out_build
    import ecg_route_pkg::*;
#(
    parameter int SW = 16,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s1_vld,
    input  logic [AW-1:0] s1_idx,
    input  logic [1:0]    s1_mode,
    input  logic [SW-1:0] s1_p1,
    input  logic [SW-1:0] lane_a_res,
    input  logic [SW-1:0] lane_b_res,
    output logic          out_vld,
    output logic [AW-1:0] out_idx,
    output logic [SW-1:0] p1_out,
    output logic [SW-1:0] p2_out
);

    logic          s2_vld;
    logic [AW-1:0] s2_idx;
    logic [1:0]    s2_mode;
    logic [SW-1:0] s2_p1;
    logic [SW-1:0] p1_nxt;
    logic [SW-1:0] p2_nxt;

    // Align slot context with the engine result cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld  <= 1'b0;
            s2_idx  <= '0;
            s2_mode <= MODE_PAR;
            s2_p1   <= '0;
        end else begin
            s2_vld  <= s1_vld;
            s2_idx  <= s1_idx;
            s2_mode <= s1_mode;
            s2_p1   <= s1_p1;
        end
    end

    // Pick the outgoing samples by mode and slot parity.
    always_comb begin
        p1_nxt = '0;
        p2_nxt = '0;
        if (s2_vld) begin
            unique case (s2_mode)
                MODE_B2B: begin
                    if (!s2_idx[0]) begin
                        p1_nxt = lane_b_res;
                        p2_nxt = lane_a_res;
                    end
                end
                MODE_EXT: begin
                    if (!s2_idx[0]) begin
                        p1_nxt = s2_p1;
                        p2_nxt = lane_b_res;
                    end
                end
                default: begin
                    p1_nxt = s2_p1;
                    p2_nxt = s2_idx[0] ? lane_b_res : lane_a_res;
                end
            endcase
        end
    end

    // Register the outgoing slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_idx <= '0;
            p1_out  <= '0;
            p2_out  <= '0;
        end else begin
            out_vld <= s2_vld;
            out_idx <= s2_vld ? s2_idx : '0;
            p1_out  <= p1_nxt;
            p2_out  <= p2_nxt;
        end
    end

endmodule

// File: rtl/ecg_group_router.sv
// Top: configuration, mode control, lane issue and output assembly for all
// canceller groups. Assumes NG is a power of two and at least 2.
module ecg_group_router
    import ecg_route_pkg::*;
#(
    parameter int NG = 16,
    parameter int SW = 16,
    parameter int DW = 8,
    localparam int AW = $clog2(2 * NG),
    localparam int GW = $clog2(NG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_page,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    output logic [NG-1:0] cfg_err,
    input  logic          frame_sync,
    input  logic          ts_valid,
    input  logic [AW-1:0] ts_idx,
    input  logic [SW-1:0] p1_in,
    input  logic [SW-1:0] p2_in,
    output logic          lane_a_vld,
    output logic [GW-1:0] lane_a_grp,
    output logic [SW-1:0] lane_a_rin,
    output logic [SW-1:0] lane_a_sin,
    output logic          lane_a_long,
    output logic          lane_a_byp,
    output logic          lane_b_vld,
    output logic [GW-1:0] lane_b_grp,
    output logic [SW-1:0] lane_b_rin,
    output logic [SW-1:0] lane_b_sin,
    output logic          lane_b_long,
    output logic          lane_b_casc,
    output logic          lane_b_byp,
    input  logic [SW-1:0] lane_a_res,
    input  logic [SW-1:0] lane_b_res,
    output logic          out_vld,
    output logic [AW-1:0] out_idx,
    output logic [SW-1:0] p1_out,
    output logic [SW-1:0] p2_out
);

    logic [NG-1:0]      ext_req;
    logic [NG-1:0]      pair_a;
    logic [NG-1:0]      pair_b;
    logic [2*NG-1:0]    byp;
    logic [NG-1:0][1:0] act_mode;
    logic [NG-1:0][1:0] eff_mode;
    logic               s1_vld;
    logic [AW-1:0]      s1_idx;
    logic [1:0]         s1_mode;
    logic [SW-1:0]      s1_p1;

    ecg_cfg_regs #(.NG(NG), .DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_page  (cfg_page),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ext_req   (ext_req),
        .pair_a    (pair_a),
        .pair_b    (pair_b),
        .byp       (byp)
    );

    ecg_mode_ctrl #(.NG(NG)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .ext_req    (ext_req),
        .pair_a     (pair_a),
        .pair_b     (pair_b),
        .cfg_err    (cfg_err),
        .act_mode   (act_mode),
        .eff_mode   (eff_mode)
    );

    ecg_lane_issue #(.NG(NG), .SW(SW), .AW(AW), .GW(GW)) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .ts_valid    (ts_valid),
        .ts_idx      (ts_idx),
        .p1_in       (p1_in),
        .p2_in       (p2_in),
        .eff_mode    (eff_mode),
        .byp         (byp),
        .lane_a_vld  (lane_a_vld),
        .lane_a_grp  (lane_a_grp),
        .lane_a_rin  (lane_a_rin),
        .lane_a_sin  (lane_a_sin),
        .lane_a_long (lane_a_long),
        .lane_a_byp  (lane_a_byp),
        .lane_b_vld  (lane_b_vld),
        .lane_b_grp  (lane_b_grp),
        .lane_b_rin  (lane_b_rin),
        .lane_b_sin  (lane_b_sin),
        .lane_b_long (lane_b_long),
        .lane_b_casc (lane_b_casc),
        .lane_b_byp  (lane_b_byp),
        .s1_vld      (s1_vld),
        .s1_idx      (s1_idx),
        .s1_mode     (s1_mode),
        .s1_p1       (s1_p1)
    );

    ecg_out_build #(.SW(SW), .AW(AW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_vld     (s1_vld),
        .s1_idx     (s1_idx),
        .s1_mode    (s1_mode),
        .s1_p1      (s1_p1),
        .lane_a_res (lane_a_res),
        .lane_b_res (lane_b_res),
        .out_vld    (out_vld),
        .out_idx    (out_idx),
        .p1_out     (p1_out),
        .p2_out     (p2_out)
    );

endmodule

// File: rtl/ecg_group_router_chk.sv
// Property checker for ecg_group_router, attached with bind below.
// Assumes: reset is synchronous and active low.
module ecg_group_router_chk #(
    parameter int NG = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ts_valid,
    input logic               ts_odd,
    input logic               frame_sync,
    input logic               cfg_page,
    input logic               addr_odd,
    input logic               rdata_ext,
    input logic               lane_a_vld,
    input logic               lane_a_long,
    input logic               lane_b_long,
    input logic               lane_b_casc,
    input logic               out_vld,
    input logic [NG-1:0][1:0] act_mode
);

    // R3: lane A is only used for an even slot one cycle earlier
    p_a_even_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lane_a_vld |-> ($past(ts_valid) && !$past(ts_odd)));

    // R6: a cascade request always comes with the A half and long tails
    p_casc_pairs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lane_b_casc |-> (lane_a_vld && lane_a_long && lane_b_long));

    // R9: active modes only move on a frame boundary
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(act_mode));

    // R2: B engine primary bit 0 never reads as set
    p_b_ext_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_page && addr_odd) |-> !rdata_ext);

    // R11: output slot follows an input slot after three cycles
    p_out_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid |-> ##3 out_vld);

    // R11: no output slot without an input slot three cycles earlier
    p_out_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_valid |-> ##3 !out_vld);

endmodule

bind ecg_group_router ecg_group_router_chk #(.NG(NG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ts_valid    (ts_valid),
    .ts_odd      (ts_idx[0]),
    .frame_sync  (frame_sync),
    .cfg_page    (cfg_page),
    .addr_odd    (cfg_addr[0]),
    .rdata_ext   (cfg_rdata[ecg_route_pkg::CTL_EXT_BIT]),
    .lane_a_vld  (lane_a_vld),
    .lane_a_long (lane_a_long),
    .lane_b_long (lane_b_long),
    .lane_b_casc (lane_b_casc),
    .out_vld     (out_vld),
    .act_mode    (act_mode)
);

// File: tb/tb_ecg_group_router.sv
`timescale 1ns/1ps
module tb_ecg_group_router;

    localparam logic [1:0] M_PAR = 2'd0;
    localparam logic [1:0] M_B2B = 2'd1;
    localparam logic [1:0] M_EXT = 2'd2;

    typedef struct packed {
        logic        ext;
        logic        bba;
        logic        bbb;
        logic [4:0]  idx;
        logic [15:0] p1;
        logic [15:0] p2;
        logic [1:0]  mode;
        logic        err;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 5'd0,  16'h1234, 16'h5678, 2'd0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 5'd1,  16'h0F0F, 16'h00FF, 2'd0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 5'd4,  16'h1111, 16'h2222, 2'd1, 1'b0},
        '{1'b0, 1'b1, 1'b1, 5'd5,  16'h3333, 16'h4444, 2'd1, 1'b0},
        '{1'b0, 1'b1, 1'b0, 5'd6,  16'h2000, 16'h0100, 2'd0, 1'b0},
        '{1'b0, 1'b0, 1'b1, 5'd7,  16'hABCD, 16'h1357, 2'd0, 1'b0},
        '{1'b1, 1'b0, 1'b0, 5'd10, 16'h0400, 16'h0800, 2'd2, 1'b0},
        '{1'b1, 1'b0, 1'b0, 5'd11, 16'h7777, 16'h1212, 2'd2, 1'b0},
        '{1'b1, 1'b1, 1'b1, 5'd30, 16'h0246, 16'h8642, 2'd2, 1'b1},
        '{1'b1, 1'b1, 1'b1, 5'd31, 16'h5555, 16'hAAAA, 2'd2, 1'b1},
        '{1'b0, 1'b1, 1'b1, 5'd28, 16'h8000, 16'hFFFF, 2'd1, 1'b0},
        '{1'b1, 1'b0, 1'b1, 5'd0,  16'hFFFF, 16'h0001, 2'd2, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_page = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [15:0] cfg_err;
    logic        frame_sync = 1'b0;
    logic        ts_valid = 1'b0;
    logic [4:0]  ts_idx = '0;
    logic [15:0] p1_in = '0;
    logic [15:0] p2_in = '0;
    logic        lane_a_vld, lane_a_long, lane_a_byp;
    logic [3:0]  lane_a_grp, lane_b_grp;
    logic [15:0] lane_a_rin, lane_a_sin, lane_b_rin, lane_b_sin;
    logic        lane_b_vld, lane_b_long, lane_b_casc, lane_b_byp;
    logic [15:0] lane_a_res = '0;
    logic [15:0] lane_b_res = '0;
    logic        out_vld;
    logic [4:0]  out_idx;
    logic [15:0] p1_out, p2_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ecg_group_router dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_page(cfg_page),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_err(cfg_err), .frame_sync(frame_sync), .ts_valid(ts_valid),
        .ts_idx(ts_idx), .p1_in(p1_in), .p2_in(p2_in),
        .lane_a_vld(lane_a_vld), .lane_a_grp(lane_a_grp), .lane_a_rin(lane_a_rin),
        .lane_a_sin(lane_a_sin), .lane_a_long(lane_a_long), .lane_a_byp(lane_a_byp),
        .lane_b_vld(lane_b_vld), .lane_b_grp(lane_b_grp), .lane_b_rin(lane_b_rin),
        .lane_b_sin(lane_b_sin), .lane_b_long(lane_b_long), .lane_b_casc(lane_b_casc),
        .lane_b_byp(lane_b_byp), .lane_a_res(lane_a_res), .lane_b_res(lane_b_res),
        .out_vld(out_vld), .out_idx(out_idx), .p1_out(p1_out), .p2_out(p2_out)
    );

    // Engine stand-ins with one cycle of latency and distinct functions.
    always @(posedge clk) begin
        lane_a_res <= lane_a_sin - lane_a_rin;
        lane_b_res <= lane_b_sin - (lane_b_rin >> 1);
    end

    function automatic logic [15:0] eng_a(input logic [15:0] rin, input logic [15:0] sin);
        return sin - rin;
    endfunction

    function automatic logic [15:0] eng_b(input logic [15:0] rin, input logic [15:0] sin);
        return sin - (rin >> 1);
    endfunction

    function automatic string tag_of(input logic [1:0] m, input logic odd);
        if (odd && m != M_PAR) return "R7";
        if (m == M_B2B) return "R5";
        if (m == M_EXT) return "R6";
        return "R3";
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic pg, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_page = pg; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic pg,
                          input logic [7:0] exp);
        @(negedge clk);
        cfg_addr = a; cfg_page = pg;
        #1;
        chk(tag, "readback", 32'(cfg_rdata), 32'(exp));
    endtask

    task automatic fsync();
        @(negedge clk);
        frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
    endtask

    // Present one slot and check lanes (T+1) and the output slot (T+3).
    task automatic run_slot(input logic fs, input logic [4:0] idx,
                            input logic [15:0] a, input logic [15:0] b,
                            input logic [1:0] m, input logic xba, input logic xbb);
        logic odd;
        logic xa, xb;
        logic [15:0] xbr, xbs, xp1, xp2;
        string t;
        odd = idx[0];
        t = tag_of(m, odd);
        xa = !odd;
        xb = odd ? (m == M_PAR) : (m != M_PAR);
        xbr = (m == M_B2B) ? b : a;
        xbs = (m == M_B2B) ? a : b;
        if (odd && m != M_PAR) begin
            xp1 = '0; xp2 = '0;
        end else if (m == M_B2B) begin
            xp1 = eng_b(b, a); xp2 = eng_a(a, b);
        end else if (m == M_EXT) begin
            xp1 = a; xp2 = eng_b(a, b);
        end else begin
            xp1 = a; xp2 = odd ? eng_b(a, b) : eng_a(a, b);
        end
        @(negedge clk);
        ts_valid = 1'b1; ts_idx = idx; p1_in = a; p2_in = b; frame_sync = fs;
        @(negedge clk);
        ts_valid = 1'b0; frame_sync = 1'b0;
        chk(t, "lane_a_vld", 32'(lane_a_vld), 32'(xa));
        chk(t, "lane_b_vld", 32'(lane_b_vld), 32'(xb));
        if (xa) begin
            chk(t, "lane_a_rin", 32'(lane_a_rin), 32'(a));
            chk(t, "lane_a_sin", 32'(lane_a_sin), 32'(b));
            chk(t, "lane_a_grp", 32'(lane_a_grp), 32'(idx[4:1]));
            chk(t, "lane_a_long", 32'(lane_a_long), 32'(m == M_EXT));
            chk("R10", "lane_a_byp", 32'(lane_a_byp), 32'(xba));
        end
        if (xb) begin
            chk(t, "lane_b_rin", 32'(lane_b_rin), 32'(xbr));
            chk(t, "lane_b_sin", 32'(lane_b_sin), 32'(xbs));
            chk(t, "lane_b_casc", 32'(lane_b_casc), 32'(m == M_EXT));
            chk(t, "lane_b_long", 32'(lane_b_long), 32'(m == M_EXT));
            chk("R10", "lane_b_byp", 32'(lane_b_byp), 32'(xbb));
        end
        @(negedge clk);
        chk("R11", "out_vld early", 32'(out_vld), 32'd0);
        @(negedge clk);
        chk("R11", "out_vld", 32'(out_vld), 32'd1);
        chk(t, "out_idx", 32'(out_idx), 32'(idx));
        chk(t, "p1_out", 32'(p1_out), 32'(xp1));
        chk(t, "p2_out", 32'(p2_out), 32'(xp2));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "out_vld", 32'(out_vld), 32'd0);
        chk("R1", "lane_a_vld", 32'(lane_a_vld), 32'd0);
        chk("R1", "lane_b_vld", 32'(lane_b_vld), 32'd0);
        chk("R1", "cfg_err", 32'(cfg_err), 32'd0);
        rd_chk("R1", 5'd0, 1'b0, 8'h00);
        rd_chk("R1", 5'd17, 1'b1, 8'h00);
        run_slot(1'b0, 5'd2, 16'h0100, 16'h0300, M_PAR, 1'b0, 1'b0);

        // R2: register storage and B-engine bit 0 masking
        wr(5'd2, 1'b0, 8'hA5);
        rd_chk("R2", 5'd2, 1'b0, 8'hA5);
        wr(5'd3, 1'b0, 8'hFF);
        rd_chk("R2", 5'd3, 1'b0, 8'hFE);
        wr(5'd9, 1'b1, 8'h3C);
        rd_chk("R2", 5'd9, 1'b1, 8'h3C);
        rd_chk("R2", 5'd9, 1'b0, 8'h00);
        wr(5'd2, 1'b0, 8'h00);
        wr(5'd3, 1'b0, 8'h00);

        // Vector table: R3..R8
        for (int i = 0; i < NV; i++) begin
            wr({VEC[i].idx[4:1], 1'b0}, 1'b0, {6'b0, VEC[i].bba, VEC[i].ext});
            wr({VEC[i].idx[4:1], 1'b1}, 1'b0, {6'b0, VEC[i].bbb, 1'b0});
            fsync();
            #1;
            chk("R8", "cfg_err", 32'(cfg_err[VEC[i].idx[4:1]]), 32'(VEC[i].err));
            // R4: mode chosen must match the pair/extended rule
            run_slot(1'b0, VEC[i].idx, VEC[i].p1, VEC[i].p2, VEC[i].mode, 1'b0, 1'b0);
        end

        // R4: one-sided pair request leaves group parallel on the even slot
        wr(5'd16, 1'b0, 8'h02);
        wr(5'd17, 1'b0, 8'h00);
        fsync();
        run_slot(1'b0, 5'd16, 16'h0042, 16'h0099, M_PAR, 1'b0, 1'b0);

        // R9: staged change waits for frame_sync; same-cycle slot sees new mode
        wr(5'd8, 1'b0, 8'h00);
        wr(5'd9, 1'b0, 8'h00);
        fsync();
        wr(5'd8, 1'b0, 8'h01);
        run_slot(1'b0, 5'd8, 16'h0600, 16'h0A00, M_PAR, 1'b0, 1'b0);
        run_slot(1'b0, 5'd9, 16'h0010, 16'h0020, M_PAR, 1'b0, 1'b0);
        run_slot(1'b1, 5'd8, 16'h0600, 16'h0A00, M_EXT, 1'b0, 1'b0);
        run_slot(1'b0, 5'd9, 16'h0010, 16'h0020, M_EXT, 1'b0, 1'b0);

        // R10: per-engine bypass flag from auxiliary bit 0
        wr(5'd12, 1'b0, 8'h00);
        wr(5'd13, 1'b0, 8'h00);
        wr(5'd13, 1'b1, 8'h01);
        fsync();
        run_slot(1'b0, 5'd13, 16'h0123, 16'h0456, M_PAR, 1'b0, 1'b1);
        run_slot(1'b0, 5'd12, 16'h0123, 16'h0456, M_PAR, 1'b0, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule